// File: doc/BRIEF.md
# Instruction Store Write Port

This block lets a host load a control store of 42-bit instruction words through three 32-bit registers: an address/control register, a low data register and a high data register. Setting the top bit of the address register opens programming mode and loads the starting index. Each word is then delivered as a low write followed by a high write. The high write joins its ten low bits with the held low value, stores the word at the current index and advances the index.

Every word carries two even-parity bits, one for each 20-bit half of the 40-bit payload. The block checks them as the word is committed and keeps a sticky error flag, which is only armed while a parity-enable input is high. The store wraps its index to zero after the last entry and stays in programming mode, so the host can detect the wrap by reading the address register back. A registered fetch port reads any entry for the execution side.

Top module: `istore_wr_port`

## Requirements
- R1: While reset is asserted and after it is released, programming mode is clear, the index is 0, `addr_rdata` reads 0 and `parity_err` is low.
- R2: A write with `host_sel` = 0 (address register) loads programming mode from `host_wdata[31]` and the index from `host_wdata[AW-1:0]`. `addr_rdata` returns programming mode in bit 31, zeros above the index and the index in the low AW bits. Writing zero ends programming mode.
- R3: A write with `host_sel` = 1 in programming mode latches all 32 bits as the low half. The value is held until it is replaced, and a high write without a new low write reuses it.
- R4: A write with `host_sel` = 2 in programming mode stores `{host_wdata[9:0], low_half}` at the current index and advances the index by one.
- R5: A high write at index DEPTH-1 stores the word and sets the index to 0 with programming mode still set, so `addr_rdata` reads 0x8000_0000. The next high write goes to entry 0.
- R6: Word bit 40 should equal the XOR of bits 19:0, and bit 41 should equal the XOR of bits 39:20. A committed word that breaks either rule sets `parity_err` in the cycle after the write, but only if `parity_en` is high during the write. The word is stored in either case.
- R7: `parity_err` stays set until reset or an address-register write with bit 31 set. An address write with bit 31 clear leaves it set.
- R8: Writes with `host_sel` 1 or 2 while programming mode is clear change nothing: no store write, no index change and no change to the held low half.
- R9: `fetch_word` shows the entry at `fetch_addr` one clock later. If a commit writes the same entry in that cycle, the fetch returns the previous contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| host_wr | input | 1 | Host register write strobe |
| host_sel | input | 2 | Register select: 0 address/control, 1 low data, 2 high data |
| host_wdata | input | 32 | Host write data |
| parity_en | input | 1 | Arms the parity check for the commit in this cycle |
| addr_rdata | output | 32 | Read-back of the address/control register |
| parity_err | output | 1 | Sticky parity error flag |
| fetch_addr | input | AW | Fetch port index |
| fetch_word | output | 42 | Store entry at the fetch index, one cycle later |

## Verification
A commit and a fetch can target the same store entry in the same cycle. The bench provokes this by loading a known word into entry 1, rewinding the index to 1 and issuing the next high write in the same cycle that `fetch_addr` selects entry 1. The fetch result one edge later must be the old word, and the new word must appear on the following cycle. The wrap from DEPTH-1 to 0 can also fall on the same commit that moves the index. The bench judges it by the `addr_rdata` read-back right after that write and by the entry that the next high write reaches.

// File: rtl/istore_pkg.sv
package istore_pkg;
  localparam int unsigned WORD_W  = 42;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned HALF_W  = 20;
  localparam int unsigned NHALF   = 2;
  localparam int unsigned UPPER_W = WORD_W - REG_W;
  localparam int unsigned PROG_BIT = 31;

  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_LO   = 2'd1,
    SEL_HI   = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/istore_regs.sv
module istore_regs
  import istore_pkg::*;
#(
  parameter int unsigned DEPTH = 1024,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [1:0]        host_sel,
  input  logic [REG_W-1:0]  host_wdata,
  output logic              prog,
  output logic [AW-1:0]     index,
  output logic              commit,
  output word_t             commit_word,
  output logic              perr_clear
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic             prog_q, prog_d;
  logic [AW-1:0]    idx_q, idx_d;
  logic [REG_W-1:0] lo_q, lo_d;
  logic             reg_en;

  assign reg_en = host_wr;

  always_comb begin
    prog_d     = prog_q;
    idx_d      = idx_q;
    lo_d       = lo_q;
    commit     = 1'b0;
    perr_clear = 1'b0;
    if (host_wr) begin
      unique case (reg_sel_e'(host_sel))
        SEL_ADDR: begin
          prog_d     = host_wdata[PROG_BIT];
          idx_d      = host_wdata[AW-1:0];
          perr_clear = host_wdata[PROG_BIT];
        end
        SEL_LO: begin
          if (prog_q) lo_d = host_wdata;
        end
        SEL_HI: begin
          if (prog_q) begin
            commit = 1'b1;
            idx_d  = (idx_q == LAST) ? '0 : idx_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_q <= 1'b0;
      idx_q  <= '0;
      lo_q   <= '0;
    end else if (reg_en) begin
      prog_q <= prog_d;
      idx_q  <= idx_d;
      lo_q   <= lo_d;
    end
  end

  assign prog        = prog_q;
  assign index       = idx_q;
  assign commit_word = {host_wdata[UPPER_W-1:0], lo_q};
endmodule

// File: rtl/istore_parity.sv
module istore_parity
  import istore_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  word_t word,
  input  logic  check,
  input  logic  parity_en,
  input  logic  clear,
  output logic  perr
);
  logic [NHALF-1:0] calc;
  logic             mismatch;
  logic             perr_q, perr_d, perr_en;

  for (genvar h = 0; h < NHALF; h++) begin : g_half
    assign calc[h] = ^word[h*HALF_W +: HALF_W];
  end

  assign mismatch = |(calc ^ word[NHALF*HALF_W +: NHALF]);
  assign perr_en  = clear | (check & parity_en);

  always_comb begin
    perr_d = perr_q;
    if (clear) perr_d = 1'b0;
    else if (check && parity_en && mismatch) perr_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) perr_q <= 1'b0;
    else if (perr_en) perr_q <= perr_d;
  end

  assign perr = perr_q;
endmodule

// File: rtl/istore_array.sv
module istore_array
  import istore_pkg::*;
#(
  parameter int unsigned DEPTH = 1024,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  word_t         wdata,
  input  logic [AW-1:0] raddr,
  output word_t         rdata
);
  word_t mem [DEPTH];
  word_t rd_q;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rd_q <= mem[raddr];
  end

  assign rdata = rd_q;
endmodule

// File: rtl/istore_wr_port.sv
module istore_wr_port
  import istore_pkg::*;
#(
  parameter int unsigned DEPTH = 1024,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [1:0]        host_sel,
  input  logic [REG_W-1:0]  host_wdata,
  input  logic              parity_en,
  output logic [REG_W-1:0]  addr_rdata,
  output logic              parity_err,
  input  logic [AW-1:0]     fetch_addr,
  output logic [WORD_W-1:0] fetch_word
);
  logic [1:0]    rst_sync_q;
  logic          rst_sync_n;
  logic          prog;
  logic [AW-1:0] index;
  logic          commit;
  word_t         commit_word;
  logic          perr_clear;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  istore_regs #(.DEPTH(DEPTH)) u_regs (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .host_wr     (host_wr),
    .host_sel    (host_sel),
    .host_wdata  (host_wdata),
    .prog        (prog),
    .index       (index),
    .commit      (commit),
    .commit_word (commit_word),
    .perr_clear  (perr_clear)
  );

  istore_parity u_par (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .word      (commit_word),
    .check     (commit),
    .parity_en (parity_en),
    .clear     (perr_clear),
    .perr      (parity_err)
  );

  istore_array #(.DEPTH(DEPTH)) u_mem (
    .clk   (clk),
    .we    (commit),
    .waddr (index),
    .wdata (commit_word),
    .raddr (fetch_addr),
    .rdata (fetch_word)
  );

  assign addr_rdata = {prog, {(REG_W-1-AW){1'b0}}, index};
endmodule

// File: rtl/istore_wr_port_chk.sv
module istore_wr_port_chk
  import istore_pkg::*;
#(
  parameter int unsigned AW = 10,
  parameter logic [AW-1:0] LAST = '1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             host_wr,
  input logic [1:0]       host_sel,
  input logic [REG_W-1:0] host_wdata,
  input logic             parity_en,
  input logic             prog,
  input logic [AW-1:0]    index,
  input logic             commit,
  input logic             parity_err
);
  // R4: high write in programming mode advances the index by one
  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && host_sel == SEL_HI && prog && index != LAST
    |=> (index - $past(index)) == AW'(1));

  // R5: wrap to zero keeps programming mode
  a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && host_sel == SEL_HI && prog && index == LAST
    |=> index == '0 && prog);

  // R8: data writes outside programming mode do not commit
  a_r8_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && host_sel != SEL_ADDR && !prog |-> !commit);

  // R8: and do not move the index
  a_r8_index_held: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && host_sel != SEL_ADDR && !prog |=> $stable(index));

  // R2: writing zero to the address register ends programming
  a_r2_end: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && host_sel == SEL_ADDR && host_wdata == '0 |=> !prog);

  // R7: error flag is sticky until a programming start
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    parity_err && !(host_wr && host_sel == SEL_ADDR && host_wdata[PROG_BIT])
    |=> parity_err);

  // R6: the flag cannot rise from a cycle with the check disarmed
  a_r6_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !parity_en |=> !$rose(parity_err));
endmodule

bind istore_wr_port istore_wr_port_chk #(.AW(AW), .LAST(AW'(DEPTH - 1))) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .host_wr    (host_wr),
  .host_sel   (host_sel),
  .host_wdata (host_wdata),
  .parity_en  (parity_en),
  .prog       (prog),
  .index      (index),
  .commit     (commit),
  .parity_err (parity_err)
);

// File: tb/test_istore_wr_port.sv
`timescale 1ns/1ps
module test_istore_wr_port;
  localparam int unsigned DEPTH = 16;
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int NVEC = 14;

  logic          clk;
  logic          rst_n;
  logic          host_wr;
  logic [1:0]    host_sel;
  logic [31:0]   host_wdata;
  logic          parity_en;
  logic [31:0]   addr_rdata;
  logic          parity_err;
  logic [AW-1:0] fetch_addr;
  logic [41:0]   fetch_word;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  istore_wr_port #(.DEPTH(DEPTH)) i_istore_wr_port (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
    .host_wdata(host_wdata), .parity_en(parity_en), .addr_rdata(addr_rdata),
    .parity_err(parity_err), .fetch_addr(fetch_addr), .fetch_word(fetch_word)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct packed {
    logic [1:0]  sel;
    logic [31:0] data;
    logic        pe;
    logic [31:0] exp_addr;
    logic        exp_perr;
  } vec_t;

  // Expected parity bits worked out from R6: 0x0F0/0x000C0300 is the
  // padding word (both halves even), low 0x1 needs bit 40 set,
  // low 0x12345678 with upper byte 0 needs bit 40 set and bit 41 clear.
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 32'h8000_0003, 1'b1, 32'h8000_0003, 1'b0}, // R2 start at 3
    '{2'd1, 32'h000C_0300, 1'b1, 32'h8000_0003, 1'b0}, // R3 low half
    '{2'd2, 32'h0000_00F0, 1'b1, 32'h8000_0004, 1'b0}, // R4 R6 padding word
    '{2'd1, 32'h0000_0001, 1'b1, 32'h8000_0004, 1'b0}, // R3
    '{2'd2, 32'h0000_0100, 1'b1, 32'h8000_0005, 1'b0}, // R6 good parity
    '{2'd1, 32'h0000_0001, 1'b1, 32'h8000_0005, 1'b0}, // R3
    '{2'd2, 32'h0000_0000, 1'b0, 32'h8000_0006, 1'b0}, // R6 bad, check off
    '{2'd2, 32'h0000_0000, 1'b1, 32'h8000_0007, 1'b1}, // R3 R6 reuse low, bad
    '{2'd1, 32'h1234_5678, 1'b1, 32'h8000_0007, 1'b1}, // R7 held
    '{2'd0, 32'h0000_0000, 1'b1, 32'h0000_0000, 1'b1}, // R2 R7 end, flag kept
    '{2'd1, 32'hDEAD_BEEF, 1'b1, 32'h0000_0000, 1'b1}, // R8 ignored
    '{2'd2, 32'h0000_03FF, 1'b1, 32'h0000_0000, 1'b1}, // R8 ignored
    '{2'd0, 32'h8000_0008, 1'b1, 32'h8000_0008, 1'b0}, // R7 cleared
    '{2'd2, 32'h0000_0100, 1'b1, 32'h8000_0009, 1'b0}  // R8 R4 uses old low
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] data, input logic pe);
    @(negedge clk);
    host_wr = 1'b1; host_sel = sel; host_wdata = data; parity_en = pe;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic fetch_chk(input string req, input logic [AW-1:0] a, input logic [41:0] exp);
    @(negedge clk);
    fetch_addr = a;
    @(negedge clk);
    check(req, 64'(fetch_word), 64'(exp));
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; host_wr = 1'b0; host_sel = 2'd0; host_wdata = '0;
    parity_en = 1'b0; fetch_addr = '0;
    repeat (3) @(negedge clk);
    check("R1 addr in reset", 64'(addr_rdata), 64'h0);
    check("R1 perr in reset", 64'(parity_err), 64'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 addr after reset", 64'(addr_rdata), 64'h0);
    check("R1 perr after reset", 64'(parity_err), 64'h0);

    for (int i = 0; i < NVEC; i++) begin
      wr(VECS[i].sel, VECS[i].data, VECS[i].pe);
      check($sformatf("R2/R4 vec %0d addr", i), 64'(addr_rdata), 64'(VECS[i].exp_addr));
      check($sformatf("R6/R7 vec %0d perr", i), 64'(parity_err), 64'(VECS[i].exp_perr));
    end

    fetch_chk("R4 R6 padding word at 3", 4'd3, 42'h0F0_000C_0300);
    fetch_chk("R4 word at 4", 4'd4, 42'h100_0000_0001);
    fetch_chk("R6 bad word stored at 6", 4'd6, 42'h000_0000_0001);
    fetch_chk("R8 R3 word at 8", 4'd8, 42'h100_1234_5678);

    // R5 wrap
    wr(2'd0, 32'h8000_000E, 1'b1);
    wr(2'd1, 32'h0000_000A, 1'b1);
    wr(2'd2, 32'h0, 1'b1);
    check("R5 before last", 64'(addr_rdata), 64'h8000_000F);
    wr(2'd2, 32'h0, 1'b1);
    check("R5 wrapped", 64'(addr_rdata), 64'h8000_0000);
    wr(2'd2, 32'h0, 1'b1);
    check("R5 continues at 0", 64'(addr_rdata), 64'h8000_0001);
    fetch_chk("R5 last entry", 4'd15, 42'h0_0000_000A);
    fetch_chk("R5 entry 0", 4'd0, 42'h0_0000_000A);

    // R9 same-cycle commit and fetch of one entry
    wr(2'd0, 32'h8000_0001, 1'b1);
    wr(2'd1, 32'h0000_0005, 1'b1);
    wr(2'd2, 32'h0, 1'b1);
    wr(2'd0, 32'h8000_0001, 1'b1);
    wr(2'd1, 32'h0000_0003, 1'b1);
    @(negedge clk);
    host_wr = 1'b1; host_sel = 2'd2; host_wdata = 32'h0; parity_en = 1'b1;
    fetch_addr = 4'd1;
    @(negedge clk);
    host_wr = 1'b0;
    check("R9 fetch sees old word", 64'(fetch_word), 64'h5);
    @(negedge clk);
    check("R9 fetch sees new word", 64'(fetch_word), 64'h3);

    wr(2'd0, 32'h0, 1'b0);
    check("R2 end programming", 64'(addr_rdata), 64'h0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule